// File: doc/BRIEF.md
# Parallel Flash Programming Sequencer

This block sits on the host side of a microcontroller's on-chip flash and runs that flash's parallel programming pins. The host hands it one command at a time: write a byte, read a byte, set one of three lock bits, read back the lock bits, erase the whole array, or read one of the signature bytes. For each command the block presents a 13-bit address split over a 5-bit high port and an 8-bit low port. It drives the 8-bit data bus only when writing and sets five mode-select lines to the pattern of the operation. It also sets a high-voltage programming enable and, for the write-type operations, issues one active-low programming strobe of fixed width.

After a strobe the device times its own write cycle. The block waits a short hold-off, then polls the ready/busy input until it reads ready. A timeout ends the wait with an error flag if the device never reports ready. Reads apply no strobe. The data bus is sampled a set number of cycles after the address and mode lines are applied. Lock-bit reads keep only the three lock bits.

Commands enter on a valid/ready channel and results leave on a second valid/ready channel. `cmd_ready` is high only while the sequencer is idle and no result is waiting. A command is taken on the clock edge where `cmd_valid` and `cmd_ready` are both high. A result stays on `rsp_data`/`rsp_err`, unchanged, until the edge where `rsp_valid` and `rsp_ready` are both high. No new command is taken while a result is held back, so a host that stalls the result channel stalls the command channel with it.

Top module: `flash_prog_seq`

## Requirements
- R1: After reset `cmd_ready`=1, `rsp_valid`=0, `pin_prog_n`=1, `pin_hv_en`=0, `pin_data_oe`=0 and `pin_mode`=0.
- R2: `pin_rst` is always 1 and `pin_psen_n` is always 0.
- R3: While a command runs, `pin_mode` (bit 0 = m0 … bit 4 = m4) carries the pattern of the opcode on `cmd_op`: 0 write byte 5'b11110, 1 read byte 5'b11000, 2 lock bit 1 5'b11111, 3 lock bit 2 5'b00111, 4 lock bit 3 5'b01101, 5 read lock bits 5'b01011, 6 chip erase 5'b00101, 7 read signature 5'b00000.
- R4: `pin_hv_en` is 1 while opcodes 0, 2, 3, 4 and 6 run, and 0 for opcodes 1, 5 and 7.
- R5: A write-type opcode (0, 2, 3, 4, 6) gives exactly one low pulse on `pin_prog_n`, STROBE_CYC clocks long, after SETUP_CYC clocks of settled pins. Read opcodes give no pulse. STROBE_CYC·CLK_PERIOD_NS must lie in 200..500 ns, or elaboration fails.
- R6: `pin_addr_hi` = address[12:8] and `pin_addr_lo` = address[7:0]. `pin_data_oe` is 1, with `pin_data_out` = `cmd_wdata`, only while opcode 0 runs.
- R7: After the strobe the block waits HOLDOFF_CYC clocks and then completes only once `pin_rdy` is sampled 1, answering with `rsp_err`=0.
- R8: If `pin_rdy` stays 0 for TIMEOUT_CYC polled clocks, the command completes with `rsp_err`=1.
- R9: Read byte returns in `rsp_data` the value of `pin_data_in` sampled SAMPLE_CYC clocks after the pins are applied.
- R10: Read lock bits returns `pin_data_in` bits 2..4 in place and zeros in every other bit.
- R11: Read signature drives address {cmd_addr[9:8], 8'h00} (high port = {3'b000, cmd_addr[9:8]}) and returns the sampled byte.
- R12: `cmd_ready` is 0 while a result is held, and `rsp_data`/`rsp_err` stay stable until the result is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken |
| cmd_op | input | 3 | Opcode (see R3) |
| cmd_addr | input | 13 | Flash address |
| cmd_wdata | input | 8 | Byte to write |
| rsp_valid | output | 1 | Result available |
| rsp_ready | input | 1 | Host takes result |
| rsp_data | output | 8 | Read result |
| rsp_err | output | 1 | Ready/busy timeout |
| pin_addr_hi | output | 5 | Address bits 12..8 |
| pin_addr_lo | output | 8 | Address bits 7..0 |
| pin_data_out | output | 8 | Data bus drive value |
| pin_data_oe | output | 1 | Data bus drive enable |
| pin_data_in | input | 8 | Data bus as seen from the device |
| pin_mode | output | 5 | Mode-select lines m0..m4 |
| pin_hv_en | output | 1 | High-voltage programming enable |
| pin_prog_n | output | 1 | Active-low programming strobe |
| pin_rst | output | 1 | Device reset line, held high |
| pin_psen_n | output | 1 | Program-store enable, held low |
| pin_rdy | input | 1 | Device ready (1) / busy (0) |

## Verification
Two things can fall in the same cycle: the host stalling a finished result and the host already offering the next command. The bench provokes this by holding `rsp_ready` low for several clocks while `cmd_valid` is high with a new read. In each of those clocks it checks that `cmd_ready` stays low, that `rsp_data` does not move and that no programming pin leaves its idle level. It then frees the result and checks that the waiting command is taken on the next idle clock and returns its own correct byte. Around this case the bench sweeps every opcode, many addresses and write values, several device busy lengths and a device that never reports ready.

// File: rtl/flash_prog_pkg.sv
package flash_prog_pkg;
  typedef enum logic [2:0] {
    OP_WRITE  = 3'd0,
    OP_READ   = 3'd1,
    OP_LOCK1  = 3'd2,
    OP_LOCK2  = 3'd3,
    OP_LOCK3  = 3'd4,
    OP_RDLOCK = 3'd5,
    OP_ERASE  = 3'd6,
    OP_SIG    = 3'd7
  } fp_op_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_STROBE, ST_HOLD, ST_POLL, ST_RESP
  } fp_state_e;

  typedef struct packed {
    logic [4:0] mode;
    logic       hv;
    logic       wr;
    logic       wbyte;
    logic       rdlock;
    logic       sig;
  } fp_ctl_t;

  localparam logic [4:0] MODE_WBYTE = 5'b11110;
endpackage

// File: rtl/fp_mode_decode.sv
module fp_mode_decode
  import flash_prog_pkg::*;
(
  input  logic [2:0] op,
  output fp_ctl_t    ctl
);
  always_comb begin
    ctl = '0;
    unique case (fp_op_e'(op))
      OP_WRITE:  begin ctl.mode = MODE_WBYTE; ctl.hv = 1'b1; ctl.wr = 1'b1; ctl.wbyte = 1'b1; end
      OP_READ:   ctl.mode = 5'b11000;
      OP_LOCK1:  begin ctl.mode = 5'b11111; ctl.hv = 1'b1; ctl.wr = 1'b1; end
      OP_LOCK2:  begin ctl.mode = 5'b00111; ctl.hv = 1'b1; ctl.wr = 1'b1; end
      OP_LOCK3:  begin ctl.mode = 5'b01101; ctl.hv = 1'b1; ctl.wr = 1'b1; end
      OP_RDLOCK: begin ctl.mode = 5'b01011; ctl.rdlock = 1'b1; end
      OP_ERASE:  begin ctl.mode = 5'b00101; ctl.hv = 1'b1; ctl.wr = 1'b1; end
      OP_SIG:    begin ctl.mode = 5'b00000; ctl.sig = 1'b1; end
      default:   ctl = '0;
    endcase
  end
endmodule

// File: rtl/fp_cycle_counter.sv
module fp_cycle_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq
  import flash_prog_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 20,
  parameter int STROBE_CYC    = 15,
  parameter int SETUP_CYC     = 2,
  parameter int SAMPLE_CYC    = 3,
  parameter int HOLDOFF_CYC   = 2,
  parameter int TIMEOUT_CYC   = 50000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  output logic        cmd_ready,
  input  logic [2:0]  cmd_op,
  input  logic [12:0] cmd_addr,
  input  logic [7:0]  cmd_wdata,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic [7:0]  rsp_data,
  output logic        rsp_err,
  output logic [4:0]  pin_addr_hi,
  output logic [7:0]  pin_addr_lo,
  output logic [7:0]  pin_data_out,
  output logic        pin_data_oe,
  input  logic [7:0]  pin_data_in,
  output logic [4:0]  pin_mode,
  output logic        pin_hv_en,
  output logic        pin_prog_n,
  output logic        pin_rst,
  output logic        pin_psen_n,
  input  logic        pin_rdy
);
  localparam int MAX_A   = (STROBE_CYC > SETUP_CYC) ? STROBE_CYC : SETUP_CYC;
  localparam int MAX_B   = (SAMPLE_CYC > HOLDOFF_CYC) ? SAMPLE_CYC : HOLDOFF_CYC;
  localparam int MAX_AB  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int MAX_CYC = (TIMEOUT_CYC > MAX_AB) ? TIMEOUT_CYC : MAX_AB;
  localparam int CNT_W   = $clog2(MAX_CYC + 1) + 1;
  localparam int STROBE_NS = STROBE_CYC * CLK_PERIOD_NS;

  // R5: strobe width must land in the 200..500 ns window
  if (STROBE_NS < 200 || STROBE_NS > 500) begin : g_bad_strobe
    $error("flash_prog_seq: strobe width %0d ns outside 200..500 ns", STROBE_NS);
  end
  if (SETUP_CYC < 1 || SAMPLE_CYC < 1 || HOLDOFF_CYC < 1 || TIMEOUT_CYC < 1) begin : g_bad_cyc
    $error("flash_prog_seq: cycle parameters must be at least 1");
  end

  fp_state_e  st, st_nx;
  fp_ctl_t    dec, ctl_q;
  logic [12:0] addr_q;
  logic [7:0]  wdata_q, rdata_q;
  logic        err_q;
  logic        cnt_load, cnt_done;
  logic [CNT_W-1:0] cnt_val;
  logic        active;

  fp_mode_decode u_dec (.op(cmd_op), .ctl(dec));

  fp_cycle_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(cnt_val), .done(cnt_done)
  );

  always_comb begin
    st_nx    = st;
    cnt_load = 1'b0;
    cnt_val  = '0;
    unique case (st)
      ST_IDLE: if (cmd_valid) begin
        st_nx    = ST_SETUP;
        cnt_load = 1'b1;
        cnt_val  = dec.wr ? CNT_W'(SETUP_CYC - 1) : CNT_W'(SAMPLE_CYC - 1);
      end
      ST_SETUP: if (cnt_done) begin
        if (ctl_q.wr) begin
          st_nx    = ST_STROBE;
          cnt_load = 1'b1;
          cnt_val  = CNT_W'(STROBE_CYC - 1);
        end else begin
          st_nx = ST_RESP;
        end
      end
      ST_STROBE: if (cnt_done) begin
        st_nx    = ST_HOLD;
        cnt_load = 1'b1;
        cnt_val  = CNT_W'(HOLDOFF_CYC - 1);
      end
      ST_HOLD: if (cnt_done) begin
        st_nx    = ST_POLL;
        cnt_load = 1'b1;
        cnt_val  = CNT_W'(TIMEOUT_CYC - 1);
      end
      ST_POLL: if (pin_rdy || cnt_done) st_nx = ST_RESP;
      ST_RESP: if (rsp_ready) st_nx = ST_IDLE;
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      ctl_q   <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      st <= st_nx;
      if (st == ST_IDLE && cmd_valid) begin
        ctl_q   <= dec;
        addr_q  <= dec.sig ? {3'b000, cmd_addr[9:8], 8'h00} : cmd_addr;
        wdata_q <= cmd_wdata;
        err_q   <= 1'b0;
        rdata_q <= '0;
      end
      if (st == ST_SETUP && cnt_done && !ctl_q.wr)
        rdata_q <= ctl_q.rdlock ? (pin_data_in & 8'h1C) : pin_data_in;
      if (st == ST_POLL && !pin_rdy && cnt_done)
        err_q <= 1'b1;
    end
  end

  assign active       = (st == ST_SETUP) || (st == ST_STROBE) || (st == ST_HOLD) || (st == ST_POLL);
  assign cmd_ready    = (st == ST_IDLE);
  assign rsp_valid    = (st == ST_RESP);
  assign rsp_data     = rdata_q;
  assign rsp_err      = err_q;
  assign pin_addr_hi  = addr_q[12:8];
  assign pin_addr_lo  = addr_q[7:0];
  assign pin_data_out = wdata_q;
  assign pin_data_oe  = active && ctl_q.wbyte;
  assign pin_mode     = active ? ctl_q.mode : 5'b00000;
  assign pin_hv_en    = active && ctl_q.hv;
  assign pin_prog_n   = (st != ST_STROBE);
  assign pin_rst      = 1'b1;
  assign pin_psen_n   = 1'b0;

  // strobe width tracker for assertion only
  logic [CNT_W-1:0] low_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           low_run <= '0;
    else if (!pin_prog_n) low_run <= low_run + 1'b1;
    else                  low_run <= '0;
  end

  AST_STROBE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pin_prog_n) |-> low_run == CNT_W'(STROBE_CYC)); // R5
  AST_STROBE_HV: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_prog_n |-> pin_hv_en); // R4
  AST_OE_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    pin_data_oe |-> (pin_hv_en && pin_mode == MODE_WBYTE)); // R6
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_err))); // R12
  AST_NO_ACCEPT_WHILE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !cmd_ready); // R12
  AST_NO_BUS_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (pin_prog_n && !pin_hv_en && !pin_data_oe)); // R1
endmodule

// File: tb/tb_flash_prog_seq.sv
module tb_flash_prog_seq;
  localparam int STROBE = 15, SETUP = 2, SAMPLE = 3, HOLD = 2, TOUT = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, rsp_ready = 1'b0;
  logic [2:0] cmd_op = '0;
  logic [12:0] cmd_addr = '0;
  logic [7:0] cmd_wdata = '0;
  logic cmd_ready, rsp_valid, rsp_err;
  logic [7:0] rsp_data, pin_addr_lo, pin_data_out, pin_data_in;
  logic [4:0] pin_addr_hi, pin_mode;
  logic pin_data_oe, pin_hv_en, pin_prog_n, pin_rst, pin_psen_n, pin_rdy;

  always #10 clk = ~clk;

  flash_prog_seq #(.CLK_PERIOD_NS(20), .STROBE_CYC(STROBE), .SETUP_CYC(SETUP),
    .SAMPLE_CYC(SAMPLE), .HOLDOFF_CYC(HOLD), .TIMEOUT_CYC(TOUT)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_err(rsp_err),
    .pin_addr_hi(pin_addr_hi), .pin_addr_lo(pin_addr_lo), .pin_data_out(pin_data_out),
    .pin_data_oe(pin_data_oe), .pin_data_in(pin_data_in), .pin_mode(pin_mode),
    .pin_hv_en(pin_hv_en), .pin_prog_n(pin_prog_n), .pin_rst(pin_rst),
    .pin_psen_n(pin_psen_n), .pin_rdy(pin_rdy));

  int n_chk = 0, n_bad = 0;
  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- device model ----------------
  int  dev_busy_len = 0;
  bit  dev_stuck = 1'b0;
  int  busy_cnt = 0;
  logic [2:0] dev_lock = 3'b000;
  always @(posedge clk) begin
    if (!pin_prog_n) begin
      busy_cnt <= dev_busy_len;
      case (pin_mode)
        5'b11111: dev_lock[0] <= 1'b1;
        5'b00111: dev_lock[1] <= 1'b1;
        5'b01101: dev_lock[2] <= 1'b1;
        default: ;
      endcase
    end else if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
  end
  assign pin_rdy = (busy_cnt == 0) && !dev_stuck;

  function automatic logic [7:0] mem_val(input logic [12:0] a);
    return a[7:0] ^ {a[12:8], 3'b101};
  endfunction
  function automatic logic [7:0] sig_val(input logic [1:0] i);
    case (i)
      2'd0: return 8'h1E;
      2'd1: return 8'h52;
      2'd2: return 8'h06;
      default: return 8'hFF;
    endcase
  endfunction

  always_comb begin
    case (pin_mode)
      5'b11000: pin_data_in = mem_val({pin_addr_hi, pin_addr_lo});
      5'b01011: pin_data_in = {3'b101, dev_lock, 2'b11};
      5'b00000: pin_data_in = (pin_addr_lo == 8'h00) ? sig_val(pin_addr_hi[1:0]) : 8'hEE;
      default:  pin_data_in = 8'hC3;
    endcase
  end

  // ---------------- pin monitor ----------------
  int setup_cnt, strobe_cnt, post_cnt, pulses;
  logic prev_prog = 1'b1;
  logic [4:0] s_mode, s_hi;
  logic [7:0] s_lo, s_dout;
  logic s_hv, s_oe;
  int fixed_bad = 0;
  always @(negedge clk) begin
    if (rst_n && (pin_rst !== 1'b1 || pin_psen_n !== 1'b0)) fixed_bad++;
    if (rst_n && !cmd_ready && !rsp_valid) begin
      if (!pin_prog_n) begin
        strobe_cnt++;
        if (prev_prog) pulses++;
      end else if (strobe_cnt == 0) setup_cnt++;
      else post_cnt++;
      s_mode = pin_mode; s_hv = pin_hv_en; s_hi = pin_addr_hi; s_lo = pin_addr_lo;
      s_oe = pin_data_oe; s_dout = pin_data_out;
    end
    prev_prog = pin_prog_n;
  end

  task automatic clr_mon();
    setup_cnt = 0; strobe_cnt = 0; post_cnt = 0; pulses = 0;
  endtask

  function automatic logic [4:0] exp_mode(input logic [2:0] op);
    case (op)
      3'd0: return 5'b11110; 3'd1: return 5'b11000; 3'd2: return 5'b11111;
      3'd3: return 5'b00111; 3'd4: return 5'b01101; 3'd5: return 5'b01011;
      3'd6: return 5'b00101; default: return 5'b00000;
    endcase
  endfunction

  logic [2:0] exp_lock = 3'b000;

  task automatic judge(input logic [2:0] op, input logic [12:0] addr, input logic [7:0] wd,
                       input int busy, input bit stuck, input logic [7:0] d, input logic e);
    bit wt = (op == 3'd0) || (op == 3'd2) || (op == 3'd3) || (op == 3'd4) || (op == 3'd6);
    logic [12:0] ea = (op == 3'd7) ? {3'b000, addr[9:8], 8'h00} : addr;
    int lo_b = (busy > HOLD) ? busy : HOLD;
    chk(s_mode == exp_mode(op), "R3 mode pattern", s_mode, exp_mode(op));
    chk(s_hv == wt, "R4 hv enable", s_hv, wt);
    chk(pulses == (wt ? 1 : 0), "R5 strobe pulse count", pulses, wt ? 1 : 0);
    chk(strobe_cnt == (wt ? STROBE : 0), "R5 strobe width", strobe_cnt, wt ? STROBE : 0);
    if (wt) chk(setup_cnt == SETUP, "R5 setup before strobe", setup_cnt, SETUP);
    chk({s_hi, s_lo} == ea, (op == 3'd7) ? "R11 signature address" : "R6 address split",
        {s_hi, s_lo}, ea);
    chk(s_oe == (op == 3'd0), "R6 data drive enable", s_oe, op == 3'd0);
    if (op == 3'd0) chk(s_dout == wd, "R6 write data", s_dout, wd);
    chk(e == stuck, stuck ? "R8 timeout error" : "R7 no error", e, stuck);
    if (wt && !stuck)
      chk(post_cnt >= lo_b && post_cnt <= busy + HOLD + 2, "R7 ready wait", post_cnt, lo_b);
    if (stuck) chk(post_cnt == HOLD + TOUT, "R8 timeout length", post_cnt, HOLD + TOUT);
    case (op)
      3'd1: begin
        chk(setup_cnt == SAMPLE, "R9 sample delay", setup_cnt, SAMPLE);
        chk(d == mem_val(addr), "R9 read byte", d, mem_val(addr));
      end
      3'd5: chk(d == {3'b000, exp_lock, 2'b00}, "R10 lock bits", d, {3'b000, exp_lock, 2'b00});
      3'd7: chk(d == sig_val(addr[9:8]), "R11 signature byte", d, sig_val(addr[9:8]));
      default: ;
    endcase
    if (op == 3'd2) exp_lock[0] = 1'b1;
    if (op == 3'd3) exp_lock[1] = 1'b1;
    if (op == 3'd4) exp_lock[2] = 1'b1;
  endtask

  task automatic issue(input logic [2:0] op, input logic [12:0] addr, input logic [7:0] wd);
    @(negedge clk);
    clr_mon();
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = addr; cmd_wdata = wd;
    while (!cmd_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic collect(input int stall, output logic [7:0] d, output logic e);
    while (!rsp_valid) @(negedge clk);
    d = rsp_data; e = rsp_err;
    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      chk(rsp_valid && rsp_data == d && rsp_err == e && !cmd_ready, "R12 result held",
          rsp_data, d);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(!rsp_valid, "R12 result released", rsp_valid, 0);
  endtask

  task automatic do_cmd(input logic [2:0] op, input logic [12:0] addr, input logic [7:0] wd,
                        input int busy, input bit stuck, input int stall);
    logic [7:0] d; logic e;
    dev_busy_len = busy; dev_stuck = stuck;
    issue(op, addr, wd);
    collect(stall, d, e);
    dev_stuck = 1'b0;
    judge(op, addr, wd, busy, stuck, d, e);
  endtask

  task automatic finish_run();
    chk(fixed_bad == 0, "R2 fixed reset/psen lines", fixed_bad, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "WATCHDOG expired", 0, 1);
    finish_run();
  end

  initial begin
    logic [7:0] d; logic e;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cmd_ready && !rsp_valid && pin_prog_n && !pin_hv_en && !pin_data_oe && pin_mode == 0,
        "R1 reset state", {cmd_ready, rsp_valid, pin_prog_n, pin_hv_en, pin_data_oe, pin_mode},
        {1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 5'b0});
    rst_n = 1'b1;
    @(negedge clk);

    // R9 read byte sweep over addresses
    for (int i = 0; i < 64; i++) do_cmd(3'd1, 13'((i * 131 + i * i * 7) % 8192), 8'h00, 0, 1'b0, 0);
    // R6 R7 write sweep, varied busy lengths and data
    for (int i = 0; i < 24; i++)
      do_cmd(3'd0, 13'((i * 397 + 5) % 8192), 8'((i * 37) ^ 8'hA5), (i % 4) * 9, 1'b0, i % 3);
    // R11 signatures
    for (int i = 0; i < 3; i++) do_cmd(3'd7, 13'(i << 8) | 13'h0C5, 8'h00, 0, 1'b0, 0);
    // R10 lock sequence: read, set each, read back
    do_cmd(3'd5, 13'h0, 8'h00, 0, 1'b0, 0);
    do_cmd(3'd2, 13'h0, 8'h00, 4, 1'b0, 0);
    do_cmd(3'd5, 13'h0, 8'h00, 0, 1'b0, 0);
    do_cmd(3'd4, 13'h0, 8'h00, 11, 1'b0, 0);
    do_cmd(3'd5, 13'h0, 8'h00, 0, 1'b0, 0);
    do_cmd(3'd3, 13'h0, 8'h00, 0, 1'b0, 0);
    do_cmd(3'd5, 13'h0, 8'h00, 0, 1'b0, 2);
    // R3 R4 chip erase with a long busy
    do_cmd(3'd6, 13'h1FFF, 8'h00, 40, 1'b0, 0);
    // R8 timeout on a write and on an erase
    do_cmd(3'd0, 13'h0ABC, 8'h3C, 0, 1'b1, 0);
    do_cmd(3'd6, 13'h0000, 8'h00, 0, 1'b1, 1);
    // recovery after timeout
    do_cmd(3'd0, 13'h1234, 8'h81, 3, 1'b0, 0);

    // R12 back-pressure with a new command waiting
    issue(3'd1, 13'h0777, 8'h00);
    while (!rsp_valid) @(negedge clk);
    d = rsp_data; e = rsp_err;
    chk(d == mem_val(13'h0777), "R9 read before stall", d, mem_val(13'h0777));
    cmd_valid = 1'b1; cmd_op = 3'd1; cmd_addr = 13'h1AB4;
    clr_mon();
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(!cmd_ready && rsp_valid && rsp_data == d && pin_prog_n && !pin_hv_en &&
          !pin_data_oe && pin_mode == 0, "R12 stall blocks new command", rsp_data, d);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(cmd_ready, "R12 idle after release", cmd_ready, 1);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(!cmd_ready, "R12 waiting command taken", cmd_ready, 0);
    collect(0, d, e);
    judge(3'd1, 13'h1AB4, 8'h00, 0, 1'b0, d, e);

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule